// File: doc/BRIEF.md
# Bus Host Interrupt Status Controller

This block gathers the interrupt sources of a bus host bridge into one status word and turns them into a single interrupt line for the CPU. The sources are the inbound and outbound descriptor engines, a bus-abort detector and the interrupt level of an external device on the bus. Each event is latched in a sticky status bit. Software reads the status word through a small register port and clears bits by writing ones to them.

A per-bit mask decides which latched bits count as pending, and a one-bit global enable gates the combined interrupt line. To help dispatch, the block also gives the index of the lowest-numbered pending bit, so a handler can pick its source without scanning the word.

The register port is a plain single-cycle interface. A write takes effect on the clock edge where it is presented. Read data is a combinational function of the address and the stored registers.

Top module: `hostbr_irq_ctrl`

## Requirements
- R1: After reset the status, mask and enable registers all read 0, `irq_o` is 0 and `irq_pend` is 0.
- R2: The status word is at offset 0x500, the mask at 0x504 and the enable at 0x508. Any other offset reads 0, and a write there changes nothing.
- R3: A one-cycle pulse on a source sets its status bit, and the bit stays set until software clears it. The mapping is: `evt_in_desc[3:0]` to bits 3..0 (completed, OK, error, end-of-list), `evt_out_desc[3:0]` to bits 7..4, `evt_in_ood` to bit 9 and `evt_bus_abort` to bit 26.
- R4: Writing the status offset clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If a source sets a bit in the same cycle as a software write clears it, the bit ends up set.
- R6: Status bit 25 follows the `ext_inta` level. It sets in every cycle where `ext_inta` is 1, so a clear has no effect while the input stays high. Once the input is low, the bit keeps its value until it is cleared.
- R7: Status bits other than 0–7, 9, 25 and 26 always read 0, and no write can set them.
- R8: The mask register holds all 32 written bits and reads them back. A bit is pending when both its status bit and its mask bit are 1.
- R9: The enable register keeps only bit 0. Its other bits always read 0.
- R10: `irq_o` is 1 exactly when the enable bit is 1 and at least one bit is pending.
- R11: `irq_pend` is 1 when any bit is pending, whatever the enable bit is. `irq_vec` then gives the index of the lowest-numbered pending bit. When nothing is pending, `irq_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_in_desc | input | 4 | Inbound descriptor event pulses (done, OK, error, end-of-list) |
| evt_out_desc | input | 4 | Outbound descriptor event pulses (done, OK, error, end-of-list) |
| evt_in_ood | input | 1 | Inbound out-of-descriptors pulse |
| evt_bus_abort | input | 1 | Bus abort pulse |
| ext_inta | input | 1 | External device interrupt level |
| irq_o | output | 1 | Combined interrupt to the CPU |
| irq_pend | output | 1 | At least one unmasked status bit is set |
| irq_vec | output | 5 | Index of the lowest pending bit |

## Verification
Every stored result (a status bit set by an event, a cleared bit, a new mask or enable value) is due on the first rising edge after the stimulus is presented. Read data, `irq_o`, `irq_pend` and `irq_vec` are combinational from the stored registers, so they are valid in the same cycle as that edge. The bench therefore changes inputs on a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. For reads it applies the address and waits a short settle delay before sampling. The same-cycle collision case (R5) and the level-held case (R6) put the write and the event into one cycle on purpose, and each is checked after that single edge.

// File: rtl/hostbr_irq_pkg.sv
package hostbr_irq_pkg;

   // Source bit positions within the status word; dispatch order depends on them.
   localparam int unsigned POS_IN_DESC  = 0;   // four bits: 0..3
   localparam int unsigned POS_OUT_DESC = 4;   // four bits: 4..7
   localparam int unsigned POS_IN_OOD   = 9;
   localparam int unsigned POS_EXT_LVL  = 25;
   localparam int unsigned POS_ABORT    = 26;
   localparam int unsigned DESC_EVTS    = 4;
   localparam int unsigned TOP_POS      = 26;

   // Mask of status bits that have storage behind them.
   function automatic logic [63:0] live_bits();
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < int'(DESC_EVTS); i++) begin
         m[POS_IN_DESC + i]  = 1'b1;
         m[POS_OUT_DESC + i] = 1'b1;
      end
      m[POS_IN_OOD]  = 1'b1;
      m[POS_EXT_LVL] = 1'b1;
      m[POS_ABORT]   = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/hostbr_irq_status.sv
module hostbr_irq_status #(
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] LIVE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] clr_vec,
   input  logic [DATA_W-1:0] set_vec,
   output logic [DATA_W-1:0] stat_q
);

   logic [DATA_W-1:0] unused_dead;
   assign unused_dead = (set_vec | clr_vec) & ~LIVE;

   for (genvar b = 0; b < int'(DATA_W); b++) begin : g_bit
      if (LIVE[b]) begin : g_live
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else begin
               // set dominates a simultaneous clear
               bit_q <= set_vec[b] | (bit_q & ~(clr_en & clr_vec[b]));
            end
         end
         assign stat_q[b] = bit_q;
      end else begin : g_dead
         assign stat_q[b] = 1'b0;
      end
   end

endmodule

// File: rtl/hostbr_irq_prio.sv
module hostbr_irq_prio #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned VEC_W  = 5
) (
   input  logic [DATA_W-1:0] pend_vec,
   output logic              any_o,
   output logic [VEC_W-1:0]  idx_o
);

   assign any_o = |pend_vec;

   // scan from the top so the lowest set index is the last one written
   always_comb begin
      idx_o = '0;
      for (int i = int'(DATA_W) - 1; i >= 0; i--) begin
         if (pend_vec[i]) begin
            idx_o = VEC_W'(i);
         end
      end
   end

endmodule

// File: rtl/hostbr_irq_regs.sv
module hostbr_irq_regs #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] OFS_STAT = 'h500,
   parameter logic [ADDR_W-1:0] OFS_MASK = 'h504,
   parameter logic [ADDR_W-1:0] OFS_EN   = 'h508
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] stat_q,
   output logic              stat_clr,
   output logic [DATA_W-1:0] mask_q,
   output logic              en_q,
   output logic [DATA_W-1:0] reg_rdata
);

   logic hit_stat, hit_mask, hit_en;

   assign hit_stat = (reg_addr == OFS_STAT);
   assign hit_mask = (reg_addr == OFS_MASK);
   assign hit_en   = (reg_addr == OFS_EN);

   assign stat_clr = reg_wr & hit_stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         en_q   <= 1'b0;
      end else if (reg_wr) begin
         if (hit_mask) mask_q <= reg_wdata;
         if (hit_en)   en_q   <= reg_wdata[0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit_stat)      reg_rdata = stat_q;
      else if (hit_mask) reg_rdata = mask_q;
      else if (hit_en)   reg_rdata = {{(DATA_W-1){1'b0}}, en_q};
   end

endmodule

// File: rtl/hostbr_irq_ctrl.sv
module hostbr_irq_ctrl
   import hostbr_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] OFS_STAT = 'h500,
   parameter logic [ADDR_W-1:0] OFS_MASK = 'h504,
   parameter logic [ADDR_W-1:0] OFS_EN   = 'h508,
   localparam int unsigned VEC_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [3:0]        evt_in_desc,
   input  logic [3:0]        evt_out_desc,
   input  logic              evt_in_ood,
   input  logic              evt_bus_abort,
   input  logic              ext_inta,
   output logic              irq_o,
   output logic              irq_pend,
   output logic [VEC_W-1:0]  irq_vec
);

   localparam logic [63:0]       LIVE_ALL = live_bits();
   localparam logic [DATA_W-1:0] LIVE     = LIVE_ALL[DATA_W-1:0];

   if (DATA_W <= TOP_POS || DATA_W > 64) begin : g_bad_width
      $error("hostbr_irq_ctrl: DATA_W must cover bit %0d and stay within 64", TOP_POS);
   end
   if (OFS_STAT == OFS_MASK || OFS_STAT == OFS_EN || OFS_MASK == OFS_EN) begin : g_bad_map
      $error("hostbr_irq_ctrl: register offsets must be distinct");
   end
   if ((OFS_STAT[1:0] | OFS_MASK[1:0] | OFS_EN[1:0]) != 2'b00) begin : g_bad_align
      $error("hostbr_irq_ctrl: register offsets must be word aligned");
   end

   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] mask_q;
   logic              en_q;
   logic              stat_clr;

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < int'(DESC_EVTS); i++) begin
         set_vec[POS_IN_DESC + i]  = evt_in_desc[i];
         set_vec[POS_OUT_DESC + i] = evt_out_desc[i];
      end
      set_vec[POS_IN_OOD]  = evt_in_ood;
      set_vec[POS_EXT_LVL] = ext_inta;
      set_vec[POS_ABORT]   = evt_bus_abort;
   end

   hostbr_irq_regs #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .OFS_STAT(OFS_STAT),
      .OFS_MASK(OFS_MASK),
      .OFS_EN  (OFS_EN)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .stat_q   (stat_q),
      .stat_clr (stat_clr),
      .mask_q   (mask_q),
      .en_q     (en_q),
      .reg_rdata(reg_rdata)
   );

   hostbr_irq_status #(
      .DATA_W(DATA_W),
      .LIVE  (LIVE)
   ) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_en (stat_clr),
      .clr_vec(reg_wdata),
      .set_vec(set_vec),
      .stat_q (stat_q)
   );

   hostbr_irq_prio #(
      .DATA_W(DATA_W),
      .VEC_W (VEC_W)
   ) u_prio (
      .pend_vec(stat_q & mask_q),
      .any_o   (irq_pend),
      .idx_o   (irq_vec)
   );

   assign irq_o = en_q & irq_pend;

endmodule

// File: rtl/hostbr_irq_chk.sv
module hostbr_irq_chk
   import hostbr_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] OFS_STAT = 'h500,
   parameter int unsigned VEC_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] set_vec,
   input logic [DATA_W-1:0] stat_q,
   input logic [DATA_W-1:0] mask_q,
   input logic              en_q,
   input logic              irq_o,
   input logic              irq_pend,
   input logic [VEC_W-1:0]  irq_vec
);

   localparam logic [63:0]       LIVE_ALL = live_bits();
   localparam logic [DATA_W-1:0] LIVE     = LIVE_ALL[DATA_W-1:0];

   logic              wr_stat;
   logic [DATA_W-1:0] below_vec;
   logic [DATA_W-1:0] pend_chk;

   assign wr_stat   = reg_wr && (reg_addr == OFS_STAT);
   assign below_vec = (DATA_W'(1) << irq_vec) - DATA_W'(1);
   assign pend_chk  = stat_q & mask_q;

   // R3: latched bits hold while no status write occurs
   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R4: written ones without a concurrent set are gone after the edge
   assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> ((stat_q & $past(reg_wdata) & ~$past(set_vec)) == '0));

   // R5: every live source that fired is latched
   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_vec & LIVE)) |=> ((stat_q & $past(set_vec & LIVE)) == $past(set_vec & LIVE)));

   // R7: bits without storage stay zero
   assert_dead_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & ~LIVE) == '0);

   // R10: the line is gated by enable and pending bits
   assert_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (en_q && (pend_chk != '0)));

   // R11: the vector names a pending bit with nothing pending below it
   assert_lowest_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend |-> (pend_chk[irq_vec] && ((pend_chk & below_vec) == '0)));

   assert_idle_vec_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_pend |-> (irq_vec == '0 && pend_chk == '0));

endmodule

bind hostbr_irq_ctrl hostbr_irq_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .OFS_STAT(OFS_STAT),
   .VEC_W   (VEC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .set_vec  (set_vec),
   .stat_q   (stat_q),
   .mask_q   (mask_q),
   .en_q     (en_q),
   .irq_o    (irq_o),
   .irq_pend (irq_pend),
   .irq_vec  (irq_vec)
);

// File: tb/hostbr_irq_ctrl_tb.sv
module hostbr_irq_ctrl_tb;

   localparam logic [11:0] A_STAT = 12'h500;
   localparam logic [11:0] A_MASK = 12'h504;
   localparam logic [11:0] A_EN   = 12'h508;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  evt_in_desc = '0;
   logic [3:0]  evt_out_desc = '0;
   logic        evt_in_ood = 1'b0;
   logic        evt_bus_abort = 1'b0;
   logic        ext_inta = 1'b0;
   logic        irq_o;
   logic        irq_pend;
   logic [4:0]  irq_vec;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   hostbr_irq_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .evt_in_desc  (evt_in_desc),
      .evt_out_desc (evt_out_desc),
      .evt_in_ood   (evt_in_ood),
      .evt_bus_abort(evt_bus_abort),
      .ext_inta     (ext_inta),
      .irq_o        (irq_o),
      .irq_pend     (irq_pend),
      .irq_vec      (irq_vec)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [3:0] din, input logic [3:0] dout,
                        input logic ood, input logic abt);
      @(negedge clk);
      evt_in_desc = din; evt_out_desc = dout; evt_in_ood = ood; evt_bus_abort = abt;
      @(negedge clk);
      evt_in_desc = '0; evt_out_desc = '0; evt_in_ood = 1'b0; evt_bus_abort = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(A_STAT, v); chk("R1 status", v, 32'h0);
      rd(A_MASK, v); chk("R1 mask", v, 32'h0);
      rd(A_EN, v);   chk("R1 enable", v, 32'h0);
      chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
      chk("R1 irq_pend", {31'h0, irq_pend}, 32'h0);
   endtask

   task automatic t_map;
      logic [31:0] v;
      wr(A_MASK, 32'hA5C3_0F96);
      rd(A_MASK, v); chk("R8 mask readback", v, 32'hA5C3_0F96);
      wr(A_EN, 32'hFFFF_FFFF);
      rd(A_EN, v); chk("R9 enable keeps bit0", v, 32'h1);
      wr(12'h50C, 32'hFFFF_FFFF);
      rd(12'h50C, v); chk("R2 unmapped reads zero", v, 32'h0);
      rd(A_MASK, v); chk("R2 unmapped write ignored", v, 32'hA5C3_0F96);
      wr(A_MASK, 32'h0);
      wr(A_EN, 32'h0);
   endtask

   task automatic t_events;
      logic [31:0] v;
      logic [31:0] exp;
      exp = '0;
      for (int i = 0; i < 4; i++) begin
         pulse(4'(1 << i), 4'h0, 1'b0, 1'b0);
         exp |= 32'(1) << i;
         rd(A_STAT, v); chk("R3 inbound event", v, exp);
      end
      for (int i = 0; i < 4; i++) begin
         pulse(4'h0, 4'(1 << i), 1'b0, 1'b0);
         exp |= 32'(1) << (4 + i);
         rd(A_STAT, v); chk("R3 outbound event", v, exp);
      end
      pulse(4'h0, 4'h0, 1'b1, 1'b0);
      exp |= 32'h0000_0200;
      rd(A_STAT, v); chk("R3 out-of-desc event", v, exp);
      pulse(4'h0, 4'h0, 1'b0, 1'b1);
      exp |= 32'h0400_0000;
      rd(A_STAT, v); chk("R3 abort event", v, exp);
      repeat (3) @(negedge clk);
      rd(A_STAT, v); chk("R3 bits sticky", v, 32'h0400_02FF);
      wr(A_STAT, 32'h0000_00F0);
      rd(A_STAT, v); chk("R4 partial clear", v, 32'h0400_020F);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, v); chk("R4 full clear", v, 32'h0);
   endtask

   task automatic t_dead_bits;
      logic [31:0] v;
      pulse(4'hF, 4'hF, 1'b1, 1'b1);
      rd(A_STAT, v); chk("R7 all sources only live bits", v, 32'h0400_02FF);
      wr(A_STAT, 32'hFFFF_FFFF);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R7 writes cannot set bits", v, 32'h0);
   endtask

   task automatic t_set_wins;
      logic [31:0] v;
      pulse(4'h0, 4'h0, 1'b0, 1'b1);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0400_0000; evt_bus_abort = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; evt_bus_abort = 1'b0;
      rd(A_STAT, v); chk("R5 set beats clear", v, 32'h0400_0000);
      wr(A_STAT, 32'h0400_0000);
      rd(A_STAT, v); chk("R5 later clear works", v, 32'h0);
   endtask

   task automatic t_level;
      logic [31:0] v;
      @(negedge clk); ext_inta = 1'b1;
      @(negedge clk);
      rd(A_STAT, v); chk("R6 level sets bit25", v, 32'h0200_0000);
      wr(A_STAT, 32'h0200_0000);
      rd(A_STAT, v); chk("R6 clear ignored while high", v, 32'h0200_0000);
      ext_inta = 1'b0;
      @(negedge clk);
      rd(A_STAT, v); chk("R6 bit holds after drop", v, 32'h0200_0000);
      wr(A_STAT, 32'h0200_0000);
      rd(A_STAT, v); chk("R6 clear after drop", v, 32'h0);
   endtask

   task automatic t_dispatch;
      logic [31:0] v;
      pulse(4'h8, 4'h8, 1'b0, 1'b0);
      wr(A_EN, 32'h1);
      chk("R10 masked gives no irq", {31'h0, irq_o}, 32'h0);
      chk("R11 masked gives no pend", {31'h0, irq_pend}, 32'h0);
      wr(A_MASK, 32'h0000_0080);
      chk("R10 unmasked irq", {31'h0, irq_o}, 32'h1);
      chk("R11 vector bit7", {27'h0, irq_vec}, 32'd7);
      wr(A_MASK, 32'h0000_0088);
      chk("R11 lowest wins", {27'h0, irq_vec}, 32'd3);
      wr(A_EN, 32'h0);
      chk("R10 disabled line low", {31'h0, irq_o}, 32'h0);
      chk("R11 pend ignores enable", {31'h0, irq_pend}, 32'h1);
      wr(A_EN, 32'hFFFF_FFFE);
      rd(A_EN, v); chk("R9 upper bits dropped", v, 32'h0);
      chk("R9 no enable from bit1", {31'h0, irq_o}, 32'h0);
      wr(A_EN, 32'h1);
      wr(A_STAT, 32'h0000_0008);
      chk("R11 next lowest", {27'h0, irq_vec}, 32'd7);
      wr(A_STAT, 32'h0000_0080);
      chk("R10 line drops when empty", {31'h0, irq_o}, 32'h0);
      chk("R11 idle vector zero", {27'h0, irq_vec}, 32'd0);
      wr(A_MASK, 32'hFFFF_FFFF);
      @(negedge clk); ext_inta = 1'b1; evt_bus_abort = 1'b1;
      @(negedge clk); ext_inta = 1'b0; evt_bus_abort = 1'b0;
      chk("R11 bit25 before bit26", {27'h0, irq_vec}, 32'd25);
      wr(A_STAT, 32'h0200_0000);
      chk("R11 then bit26", {27'h0, irq_vec}, 32'd26);
      wr(A_STAT, 32'hFFFF_FFFF);
      wr(A_MASK, 32'h0);
      wr(A_EN, 32'h0);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 20000) begin
         errors++;
         $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 20000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_events();
      t_dead_bits();
      t_set_wins();
      t_level();
      t_dispatch();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule